// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Host Sequencer

This block runs one conversion at a time on an external 12-bit serial converter that samples its channels together. A user asks for a conversion with a channel address, an input mode (single-ended, pseudo-differential or fully differential) and a range select, all on a valid/ready handshake. The sequencer puts those choices on the converter's configuration pins and waits for the acquisition time. It then lowers the chip select and clocks out a 14-cycle serial frame. It drops the two leading bits and returns the 12 data bits.

The converter gives two's complement only in fully differential mode. Every other mode gives straight binary. The sequencer publishes the raw code and a flag that names the coding. It also publishes a normalised sample that is always in two's complement form. To get it, the sequencer inverts the MSB of every straight-binary result.

Acquisition is timed from the last moment the analog input could have started tracking. That moment is either a change on any configuration pin or the track-and-hold returning to track inside the previous frame. A request that repeats the current configuration after a long idle period therefore starts its frame at once. A request that changes the mode, range or channel waits the full acquisition period.

Top module: `adcSeqTop`

## Requirements
- R1: After reset, reqReady is 1, adcCsN is 1, adcSclk is 1 and resValid is 0. The configuration pins rest at pinSingle=1, pinPseudo=0, pinRange=0 and pinChan=0.
- R2: reqReady is 0 from the clock edge that accepts a request (reqValid and reqReady both 1) until the edge where adcCsN returns high. A request held valid during a frame is taken on the first edge after that and is not lost.
- R3: The edge that accepts a request also loads the pins. reqMode 0 gives pinSingle=1 and pinPseudo=0. reqMode 1 gives pinSingle=0 and pinPseudo=1. reqMode 2 and 3 both mean fully differential, with both pins 0. pinRange takes reqRange and pinChan takes reqChan.
- R4: A request that changes any configuration pin restarts acquisition. adcCsN falls exactly ACQ_CYCLES+1 clock edges after the accepting edge.
- R5: The acquisition timer also restarts on the 13th SCLK rising edge of each frame and at reset, and it saturates at ACQ_CYCLES. A request that changes no pin lowers adcCsN on the first edge after acceptance if the timer has already saturated. Otherwise adcCsN falls once the timer reaches ACQ_CYCLES. A request held through a frame with an unchanged configuration therefore sees adcCsN fall ACQ_CYCLES-2*HALF_CYCLES edges after acceptance.
- R6: While adcCsN is low, adcSclk starts high and toggles every HALF_CYCLES clocks, giving 14 falling edges. adcCsN stays low for 28*HALF_CYCLES clocks and rises on the same edge as the 14th SCLK rise. adcSclk is high whenever adcCsN is high.
- R7: adcDout is sampled on each SCLK falling edge, MSB first. The first two bits of a frame are discarded whatever their value. resRaw holds bits 3 to 14 of the frame, in order from bit 11 down to bit 0.
- R8: resTwos is 1 only for fully differential requests. resSample equals resRaw when resTwos is 1, and otherwise equals resRaw with bit 11 inverted.
- R9: resValid is a one-cycle pulse on the edge where adcCsN rises. resRaw, resSample and resTwos hold their values until the next result.
- R10: The configuration pins do not change between the accepting edge and the end of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Conversion request valid |
| reqReady | output | 1 | Sequencer can accept a request |
| reqMode | input | 2 | 0 single-ended, 1 pseudo-differential, 2/3 fully differential |
| reqRange | input | 1 | 0 narrow range, 1 double range |
| reqChan | input | CHAN_BITS (3) | Channel address |
| adcCsN | output | 1 | Converter chip select, active low |
| adcSclk | output | 1 | Serial clock, idle high |
| adcDout | input | 1 | Serial data from the converter |
| pinSingle | output | 1 | High selects single-ended inputs |
| pinPseudo | output | 1 | High selects pseudo-differential when not single-ended |
| pinRange | output | 1 | Range select pin |
| pinChan | output | CHAN_BITS (3) | Channel address pins |
| resValid | output | 1 | One-cycle result strobe |
| resRaw | output | DATA_BITS (12) | Code as delivered by the converter |
| resSample | output | DATA_BITS (12) | Sample normalised to two's complement |
| resTwos | output | 1 | 1 when the raw code was two's complement |

## Verification
The hardest situation to reach from the ports is a request accepted while the acquisition timer is partly run, neither freshly cleared nor saturated. That only happens when a request with the same configuration is already waiting as a frame ends. The bench gets there by raising a second request while the first frame is still clocking, so it is taken on the edge right after chip select rises. It then checks that chip select falls after ACQ_CYCLES-2*HALF_CYCLES edges, not one edge and not a full period. Separate requests first re-issue the reset configuration and then change only the range, which pins down the other two acquisition paths.

// File: rtl/adcSeqPkg.sv
package adcSeqPkg;

  // Requested input configuration; code 3 aliases fully differential.
  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'd0,
    MODE_PSEUDO   = 2'd1,
    MODE_DIFF     = 2'd2,
    MODE_DIFF_ALT = 2'd3
  } cfgMode_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic loadCfg;  // request accepted: latch pin values
    logic shiftIn;  // SCLK falling edge: take one serial bit
    logic publish;  // frame over: present the result
  } seqStrobe_t;

endpackage

// File: rtl/adcSeqCtrl.sv
module adcSeqCtrl
  import adcSeqPkg::*;
#(
  parameter int FRAME_SCLKS = 14,
  parameter int ACQ_CYCLES  = 20,
  parameter int HALF_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       cfgDiffers,
  output logic       reqReady,
  output logic       adcCsN,
  output logic       adcSclk,
  output seqStrobe_t strobe
);

  localparam int ACQ_W    = $clog2(ACQ_CYCLES + 1);
  localparam int HALF_W   = $clog2(HALF_CYCLES + 1);
  localparam int FALL_W   = $clog2(FRAME_SCLKS + 1);
  localparam int TRACK_AT = FRAME_SCLKS - 1;

  typedef enum logic [1:0] {ST_IDLE, ST_ACQ, ST_FRAME} seqState_e;

  seqState_e          state;
  logic [ACQ_W-1:0]   acqCnt;
  logic [HALF_W-1:0]  halfCnt;
  logic [FALL_W-1:0]  fallCnt;

  logic accept, acqDone, halfWrap, fallEdge, riseEdge, trackStrobe, endStrobe;

  always_comb begin
    accept      = reqValid && (state == ST_IDLE);
    acqDone     = (acqCnt == ACQ_W'(ACQ_CYCLES));
    halfWrap    = (halfCnt == HALF_W'(HALF_CYCLES - 1));
    fallEdge    = (state == ST_FRAME) && halfWrap && adcSclk;
    riseEdge    = (state == ST_FRAME) && halfWrap && !adcSclk;
    trackStrobe = riseEdge && (fallCnt == FALL_W'(TRACK_AT));
    endStrobe   = riseEdge && (fallCnt == FALL_W'(FRAME_SCLKS));
    reqReady    = (state == ST_IDLE);
    strobe.loadCfg = accept;
    strobe.shiftIn = fallEdge;
    strobe.publish = endStrobe;
  end

  // Acquisition timer: cleared by a pin change or by track return.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      acqCnt <= '0;
    end else if ((accept && cfgDiffers) || trackStrobe) begin
      acqCnt <= '0;
    end else if (!acqDone) begin
      acqCnt <= acqCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      adcCsN  <= 1'b1;
      adcSclk <= 1'b1;
      halfCnt <= '0;
      fallCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) state <= ST_ACQ;
        end
        ST_ACQ: begin
          if (acqDone) begin
            adcCsN  <= 1'b0;
            adcSclk <= 1'b1;
            halfCnt <= '0;
            fallCnt <= '0;
            state   <= ST_FRAME;
          end
        end
        ST_FRAME: begin
          if (halfWrap) begin
            halfCnt <= '0;
            adcSclk <= ~adcSclk;
            if (fallEdge) begin
              fallCnt <= fallCnt + 1'b1;
            end else if (endStrobe) begin
              adcCsN <= 1'b1;
              state  <= ST_IDLE;
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adcSeqData.sv
module adcSeqData
  import adcSeqPkg::*;
#(
  parameter int DATA_BITS = 12,
  parameter int CHAN_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic [1:0]           reqMode,
  input  logic                 reqRange,
  input  logic [CHAN_BITS-1:0] reqChan,
  input  logic                 adcDout,
  output logic                 cfgDiffers,
  output logic                 pinSingle,
  output logic                 pinPseudo,
  output logic                 pinRange,
  output logic [CHAN_BITS-1:0] pinChan,
  output logic                 resValid,
  output logic [DATA_BITS-1:0] resRaw,
  output logic [DATA_BITS-1:0] resSample,
  output logic                 resTwos
);

  localparam int MSB = DATA_BITS - 1;

  logic                 decSingle, decPseudo, twosNow;
  logic [DATA_BITS-1:0] shiftReg;

  always_comb begin
    decSingle  = (reqMode == MODE_SINGLE);
    decPseudo  = (reqMode == MODE_PSEUDO);
    cfgDiffers = {decSingle, decPseudo, reqRange, reqChan} !=
                 {pinSingle, pinPseudo, pinRange, pinChan};
    twosNow    = !pinSingle && !pinPseudo;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinSingle <= 1'b1;
      pinPseudo <= 1'b0;
      pinRange  <= 1'b0;
      pinChan   <= '0;
    end else if (strobe.loadCfg) begin
      pinSingle <= decSingle;
      pinPseudo <= decPseudo;
      pinRange  <= reqRange;
      pinChan   <= reqChan;
    end
  end

  // Only DATA_BITS are kept: leading bits fall off the top.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.shiftIn) begin
      shiftReg <= {shiftReg[MSB-1:0], adcDout};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      resRaw    <= '0;
      resSample <= '0;
      resTwos   <= 1'b0;
    end else begin
      resValid <= strobe.publish;
      if (strobe.publish) begin
        resRaw    <= shiftReg;
        resTwos   <= twosNow;
        resSample <= twosNow ? shiftReg : {~shiftReg[MSB], shiftReg[MSB-1:0]};
      end
    end
  end

endmodule

// File: rtl/adcSeqTop.sv
module adcSeqTop
  import adcSeqPkg::*;
#(
  parameter int DATA_BITS   = 12,
  parameter int LEAD_BITS   = 2,
  parameter int CHAN_BITS   = 3,
  parameter int ACQ_CYCLES  = 20,
  parameter int HALF_CYCLES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [1:0]           reqMode,
  input  logic                 reqRange,
  input  logic [CHAN_BITS-1:0] reqChan,
  output logic                 adcCsN,
  output logic                 adcSclk,
  input  logic                 adcDout,
  output logic                 pinSingle,
  output logic                 pinPseudo,
  output logic                 pinRange,
  output logic [CHAN_BITS-1:0] pinChan,
  output logic                 resValid,
  output logic [DATA_BITS-1:0] resRaw,
  output logic [DATA_BITS-1:0] resSample,
  output logic                 resTwos
);

  localparam int FRAME_SCLKS = DATA_BITS + LEAD_BITS;

  seqStrobe_t strobe;
  logic       cfgDiffers;

  adcSeqCtrl #(
    .FRAME_SCLKS(FRAME_SCLKS),
    .ACQ_CYCLES (ACQ_CYCLES),
    .HALF_CYCLES(HALF_CYCLES)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .cfgDiffers(cfgDiffers),
    .reqReady  (reqReady),
    .adcCsN    (adcCsN),
    .adcSclk   (adcSclk),
    .strobe    (strobe)
  );

  adcSeqData #(
    .DATA_BITS(DATA_BITS),
    .CHAN_BITS(CHAN_BITS)
  ) data_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqMode   (reqMode),
    .reqRange  (reqRange),
    .reqChan   (reqChan),
    .adcDout   (adcDout),
    .cfgDiffers(cfgDiffers),
    .pinSingle (pinSingle),
    .pinPseudo (pinPseudo),
    .pinRange  (pinRange),
    .pinChan   (pinChan),
    .resValid  (resValid),
    .resRaw    (resRaw),
    .resSample (resSample),
    .resTwos   (resTwos)
  );

endmodule

// File: rtl/adcSeqChecker.sv
module adcSeqChecker #(
  parameter int ACQ_CYCLES = 20,
  parameter int CHAN_BITS  = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqReady,
  input logic                 adcCsN,
  input logic                 adcSclk,
  input logic                 pinSingle,
  input logic                 pinPseudo,
  input logic                 pinRange,
  input logic [CHAN_BITS-1:0] pinChan,
  input logic                 resValid,
  input logic                 resTwos
);

  localparam int CNT_W = $clog2(ACQ_CYCLES + 2);
  localparam int CFG_W = CHAN_BITS + 3;

  logic [CFG_W-1:0] cfgVec, prevCfg;
  logic [CNT_W-1:0] sinceCfg;

  assign cfgVec = {pinSingle, pinPseudo, pinRange, pinChan};

  // Clocks since the configuration pins last moved.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCfg  <= cfgVec;
      sinceCfg <= '0;
    end else begin
      prevCfg <= cfgVec;
      if (cfgVec != prevCfg) sinceCfg <= CNT_W'(1);
      else if (sinceCfg != CNT_W'(ACQ_CYCLES + 1)) sinceCfg <= sinceCfg + 1'b1;
    end
  end

  // R2
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !adcCsN |-> !reqReady);

  // R6
  idle_sclk_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcCsN |-> adcSclk);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && $past(!reqReady)) |-> $stable(cfgVec));

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  // R9
  valid_csn_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (adcCsN && $past(!adcCsN)));

  // R8
  coding_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resTwos == (!pinSingle && !pinPseudo)));

  // R4
  acq_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcCsN) |-> (sinceCfg >= CNT_W'(ACQ_CYCLES)));

  // R3
  mode_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pinSingle, pinPseudo}));

endmodule

bind adcSeqTop adcSeqChecker #(
  .ACQ_CYCLES(ACQ_CYCLES),
  .CHAN_BITS (CHAN_BITS)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .adcCsN   (adcCsN),
  .adcSclk  (adcSclk),
  .pinSingle(pinSingle),
  .pinPseudo(pinPseudo),
  .pinRange (pinRange),
  .pinChan  (pinChan),
  .resValid (resValid),
  .resTwos  (resTwos)
);

// File: tb/adcSeqTop_tb_top.sv
`timescale 1ns/1ps
module adcSeqTop_tb_top;

  localparam int ACQ  = 20;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqReady, reqRange, adcCsN, adcSclk, adcDout;
  logic [1:0]  reqMode;
  logic [2:0]  reqChan, pinChan;
  logic        pinSingle, pinPseudo, pinRange, resValid, resTwos;
  logic [11:0] resRaw, resSample;

  int nChecks = 0;
  int nFails  = 0;

  logic [13:0] frameBits = '0;
  int          bitIdx = 0;

  always #10 clk = ~clk;

  adcSeqTop #(.ACQ_CYCLES(ACQ), .HALF_CYCLES(HALF)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqMode(reqMode), .reqRange(reqRange), .reqChan(reqChan),
    .adcCsN(adcCsN), .adcSclk(adcSclk), .adcDout(adcDout),
    .pinSingle(pinSingle), .pinPseudo(pinPseudo), .pinRange(pinRange),
    .pinChan(pinChan), .resValid(resValid), .resRaw(resRaw),
    .resSample(resSample), .resTwos(resTwos)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Converter model: bit 13 of frameBits appears first, next bit after each SCLK fall.
  always @(negedge adcCsN) begin
    bitIdx = 0;
    adcDout <= frameBits[13];
  end
  always @(negedge adcSclk) begin
    if (!adcCsN && bitIdx < 13) begin
      bitIdx++;
      adcDout <= frameBits[13 - bitIdx];
    end
  end

  // Frame shape monitor (R6).
  int lowCnt = 0, falls = 0, runLen = 0;
  bit runBad = 0, prevCsn = 1, prevSclk = 1;
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      if (!adcCsN && prevCsn) begin
        lowCnt = 0; falls = 0; runLen = 0; runBad = 0;
      end
      if (!adcCsN) begin
        lowCnt++;
        if (adcSclk != prevSclk) begin
          if (runLen != HALF) runBad = 1;
          runLen = 1;
          if (!adcSclk) falls++;
        end else begin
          runLen++;
        end
      end
      if (adcCsN && !prevCsn) begin
        check(lowCnt == 28 * HALF, "R6", "CSN low clocks", lowCnt, 28 * HALF);
        check(falls == 14, "R6", "SCLK falls", falls, 14);
        check(!runBad, "R6", "SCLK half period", runBad, 0);
      end
      prevCsn  = adcCsN;
      prevSclk = adcSclk;
    end
  end

  // Called at a falling clock edge; returns at the falling edge showing resValid.
  task automatic doConv(input logic [1:0] mode, input logic rng, input logic [2:0] ch,
                        input logic [1:0] lead, input logic [11:0] data,
                        input int expLat, input string latReq);
    int  n;
    bit  busyBad;
    bit  twos;
    logic [11:0] expSample;
    frameBits = {lead, data};
    reqMode = mode; reqRange = rng; reqChan = ch; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check({pinSingle, pinPseudo, pinRange, pinChan} ==
          {mode == 2'd0, mode == 2'd1, rng, ch}, "R3", "pins after accept",
          {pinSingle, pinPseudo, pinRange, pinChan}, {mode == 2'd0, mode == 2'd1, rng, ch});
    busyBad = 0;
    n = 1;
    while (adcCsN) begin
      if (reqReady) busyBad = 1;
      @(negedge clk);
      n++;
    end
    check(n - 1 == expLat, latReq, "accept-to-CSN latency", n - 1, expLat);
    while (!resValid) begin
      if (reqReady) busyBad = 1;
      @(negedge clk);
    end
    check(!busyBad, "R2", "ready low while busy", busyBad, 0);
    twos = (mode >= 2'd2);
    expSample = twos ? data : {~data[11], data[10:0]};
    check(resRaw == data, "R7", "raw code", resRaw, data);
    check(resTwos == twos, "R8", "coding flag", resTwos, twos);
    check(resSample == expSample, "R8", "normalised sample", resSample, expSample);
  endtask

  task automatic idle(input int cycles);
    repeat (cycles) @(negedge clk);
  endtask

  task automatic testReset();
    check(reqReady == 1'b1, "R1", "reqReady", reqReady, 1);
    check(adcCsN == 1'b1 && adcSclk == 1'b1, "R1", "CSN/SCLK idle", {adcCsN, adcSclk}, 3);
    check(resValid == 1'b0, "R1", "resValid", resValid, 0);
    check({pinSingle, pinPseudo, pinRange, pinChan} == 6'b100000, "R1", "pin rest",
          {pinSingle, pinPseudo, pinRange, pinChan}, 6'b100000);
  endtask

  task automatic testSameAsReset();
    idle(ACQ + 5);
    doConv(2'd0, 1'b0, 3'd0, 2'b00, 12'h5A3, 1, "R5");
  endtask

  task automatic testChannelChange();
    idle(ACQ + 5);
    doConv(2'd0, 1'b0, 3'd5, 2'b11, 12'hABC, ACQ + 1, "R4");
    @(negedge clk);
    check(resValid == 1'b0, "R9", "pulse width", resValid, 0);
    check(resRaw == 12'hABC && resSample == 12'h2BC, "R9", "result held", resRaw, 12'hABC);
  endtask

  task automatic testPseudo();
    idle(ACQ + 5);
    doConv(2'd1, 1'b0, 3'd5, 2'b00, 12'h800, ACQ + 1, "R4");
  endtask

  task automatic testDiff();
    idle(ACQ + 5);
    doConv(2'd2, 1'b0, 3'd5, 2'b10, 12'hFFF, ACQ + 1, "R4");
  endtask

  task automatic testModeAlias();
    idle(ACQ + 5);
    doConv(2'd3, 1'b0, 3'd5, 2'b01, 12'h800, 1, "R5");
  endtask

  task automatic testRange();
    idle(ACQ + 5);
    doConv(2'd2, 1'b1, 3'd5, 2'b00, 12'h400, ACQ + 1, "R4");
  endtask

  task automatic testHeldRequest();
    idle(ACQ + 5);
    fork
      doConv(2'd2, 1'b1, 3'd5, 2'b00, 12'h123, 1, "R5");
      begin
        @(negedge clk);
        while (adcCsN) @(negedge clk);
        reqMode = 2'd2; reqRange = 1'b1; reqChan = 3'd5; reqValid = 1'b1;
      end
    join
    doConv(2'd2, 1'b1, 3'd5, 2'b01, 12'h7FF, ACQ - 2 * HALF, "R5");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqMode = 2'd0; reqRange = 1'b0; reqChan = 3'd0;
    adcDout = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSameAsReset();
    testChannelChange();
    testPseudo();
    testDiff();
    testModeAlias();
    testRange();
    testHeldRequest();
    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule